// File: doc/BRIEF.md
# De Bruijn Sequence Counter

This block is a synchronous counter that walks through every one of the 2^W values of a W-bit register, the all-zero value included, in a fixed pseudo-random order. It is built on a shift register with linear feedback. The register moves one place toward bit 0 on each enabled clock, and a computed bit enters at the top. In the plain form of such a register the all-zero value can never appear, because it would feed back zeros forever. Here an extra term is folded into the feedback. It detects when every bit above bit 0 is clear, and this places the zero value between 0..01 and 10..00.

A user can take the whole register as a cheap counter state, or use the single serial bit. Over one period, any W consecutive serial bits form a different pattern, and all 2^W patterns appear. The width, the tap mask of a primitive polynomial and the reset seed are parameters.

Top module: `debruijn_counter`

## Requirements
- R1: A clock edge with `rst` high loads `state_o` with the parameter SEED (default: bit W-1 set, all other bits clear) and loads `serial_o` with bit 0 of SEED.
- R2: A clock edge with `en` low and `rst` low leaves `state_o` and `serial_o` unchanged.
- R3: On an enabled edge the register shifts toward bit 0: the new bits W-2..0 equal the old bits W-1..1.
- R4: The bit entering at position W-1 is the XOR of the old bits selected by TAP_MASK (default for W=4: bits 0 and 1, mask 4'b0011) and a zero-detect term that is 1 when old bits W-1..1 are all 0.
- R5: An enabled edge from state 0..01 gives 0..00, and an enabled edge from 0..00 gives 10..00.
- R6: Under continuous enable, the state returns to its start value after exactly 2^W steps, and every W-bit value appears once in that period.
- R7: `serial_o` always equals bit 0 of `state_o`.
- R8: Over one period of the serial stream, the 2^W windows of W consecutive bits (taken cyclically) are all distinct.
- R9: With SEED set to all zeros, the counter still runs the full 2^W-state cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Step enable, active high |
| state_o | output | WIDTH | Registered counter state |
| serial_o | output | 1 | Registered serial bit, bit 0 of the state |

## Verification
The assertions assume that `en` and `rst` are clean levels that are sampled at the rising edge. They also assume that TAP_MASK names a primitive polynomial with bit 0 set. The period properties depend on that polynomial choice, so they are checked against a bench model and not by assertion. The stimulus changes `en` and `rst` only on falling edges. It uses seeded random enable patterns, long stretches of continuous enable to check the period and the serial windows, and a second instance with an all-zero seed.

// File: rtl/dbc_pkg.sv
package dbc_pkg;
  // XOR of the bits of a vector picked out by a mask
  function automatic logic masked_parity(input logic [63:0] v, input logic [63:0] m);
    return ^(v & m);
  endfunction
endpackage

// File: rtl/dbc_zero_detect.sv
module dbc_zero_detect #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] state,
  output logic             upper_zero
);
  localparam int UPPER = WIDTH - 1;
  logic [UPPER-1:0] upper;
  assign upper      = state[WIDTH-1:1];
  assign upper_zero = (upper == '0);
endmodule

// File: rtl/dbc_feedback.sv
module dbc_feedback #(
  parameter int               WIDTH    = 4,
  parameter logic [WIDTH-1:0] TAP_MASK = 4'b0011
) (
  input  logic [WIDTH-1:0] state,
  input  logic             upper_zero,
  output logic             fb
);
  import dbc_pkg::*;
  logic [63:0] s_ext;
  logic [63:0] m_ext;
  assign s_ext = 64'(state);
  assign m_ext = 64'(TAP_MASK);
  assign fb    = masked_parity(s_ext, m_ext) ^ upper_zero;
endmodule

// File: rtl/dbc_state_reg.sv
module dbc_state_reg #(
  parameter int               WIDTH = 4,
  parameter logic [WIDTH-1:0] SEED  = 4'b1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             fb,
  output logic [WIDTH-1:0] state,
  output logic             serial
);
  logic [WIDTH-1:0] nxt;
  assign nxt = {fb, state[WIDTH-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= SEED;
      serial <= SEED[0];
    end else if (en) begin
      state  <= nxt;
      serial <= nxt[0];
    end
  end

  // R3
  shift_chk: assert property (@(posedge clk) disable iff (rst)
    en |=> state[WIDTH-2:0] == $past(state[WIDTH-1:1]));
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(state) && $stable(serial));
endmodule

// File: rtl/debruijn_counter.sv
module debruijn_counter #(
  parameter int               WIDTH    = 4,
  parameter logic [WIDTH-1:0] TAP_MASK = 4'b0011,
  parameter logic [WIDTH-1:0] SEED    = {1'b1, {(WIDTH-1){1'b0}}}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  output logic [WIDTH-1:0] state_o,
  output logic             serial_o
);
  localparam logic [WIDTH-1:0] ONE_LOW  = {{(WIDTH-1){1'b0}}, 1'b1};
  localparam logic [WIDTH-1:0] ONE_HIGH = {1'b1, {(WIDTH-1){1'b0}}};

  logic upper_zero;
  logic fb;

  dbc_zero_detect #(.WIDTH(WIDTH)) u_zd (
    .state      (state_o),
    .upper_zero (upper_zero)
  );

  dbc_feedback #(.WIDTH(WIDTH), .TAP_MASK(TAP_MASK)) u_fb (
    .state      (state_o),
    .upper_zero (upper_zero),
    .fb         (fb)
  );

  dbc_state_reg #(.WIDTH(WIDTH), .SEED(SEED)) u_reg (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .fb     (fb),
    .state  (state_o),
    .serial (serial_o)
  );

  // R5
  into_zero_chk: assert property (@(posedge clk) disable iff (rst)
    en && state_o == ONE_LOW |=> state_o == '0);
  // R5
  out_of_zero_chk: assert property (@(posedge clk) disable iff (rst)
    en && state_o == '0 |=> state_o == ONE_HIGH);
  // R7
  serial_bit_chk: assert property (@(posedge clk) disable iff (rst)
    serial_o == state_o[0]);
endmodule

// File: tb/tb_debruijn_counter.sv
module tb_debruijn_counter;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;
  localparam int N = 1 << W;
  localparam logic [W-1:0] TAPS = 4'b0011;

  logic clk = 0;
  logic rst = 1;
  logic en  = 0;
  logic [W-1:0] st, stz;
  logic ser, serz;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  debruijn_counter #(.WIDTH(W), .TAP_MASK(TAPS)) dut (
    .clk(clk), .rst(rst), .en(en), .state_o(st), .serial_o(ser));
  debruijn_counter #(.WIDTH(W), .TAP_MASK(TAPS), .SEED('0)) dut_z (
    .clk(clk), .rst(rst), .en(en), .state_o(stz), .serial_o(serz));

  // bench model of one step, from R3/R4
  function automatic logic [W-1:0] step_fn(input logic [W-1:0] s);
    logic b = 1'b0;
    for (int i = 0; i < W; i++) if (TAPS[i]) b = b ^ s[i];
    if (s[W-1:1] == 0) b = ~b;
    return {b, s[W-1:1]};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  logic [W-1:0] m, mz;

  // drive at negedge; outputs are compared at the following negedge
  task automatic cyc(input logic e);
    @(negedge clk);
    en = e;
    if (e) begin m = step_fn(m); mz = step_fn(mz); end
    @(negedge clk);
    en = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit seen [N];
    bit wseen [N];
    logic bits [2*N];
    void'($urandom(32'd1234));
    rst = 1;
    repeat (3) @(negedge clk);
    chk(st == 4'b1000, "R1", st, 8);
    chk(ser == 1'b0, "R1", ser, 0);
    chk(stz == 4'b0000, "R1", stz, 0);
    rst = 0;
    m = 4'b1000; mz = 4'b0000;

    // R2 hold with enable low
    cyc(0); cyc(0);
    chk(st == m, "R2", st, m);

    // random enable pattern against the model (R3 R4 R7)
    for (int k = 0; k < 300; k++) begin
      cyc($urandom_range(0, 1));
      chk(st == m, "R4", st, m);
      chk(stz == mz, "R9", stz, mz);
      chk(ser == st[0], "R7", ser, st[0]);
    end

    // directed R5: bring state to 0001 and step
    while (st != 4'b0001) cyc(1);
    cyc(1);
    chk(st == 4'b0000, "R5", st, 0);
    cyc(0);
    chk(st == 4'b0000, "R2", st, 0);
    cyc(1);
    chk(st == 4'b1000, "R5", st, 8);

    // R6/R8 period, uniqueness and serial windows
    for (int i = 0; i < N; i++) seen[i] = 0;
    for (int i = 0; i < N; i++) begin
      if (i > 0) chk(st != 4'b1000, "R6", st, 8);
      chk(!seen[st], "R6", st, -1);
      seen[st] = 1;
      bits[i] = ser;
      cyc(1);
    end
    chk(st == 4'b1000, "R6", st, 8);
    for (int i = 0; i < N; i++) chk(seen[i], "R6", 0, i);
    for (int i = 0; i < N; i++) wseen[i] = 0;
    for (int i = 0; i < N; i++) begin
      int v = 0;
      for (int j = 0; j < W; j++) v = (v << 1) | int'(bits[(i + j) % N]);
      chk(!wseen[v], "R8", v, -1);
      wseen[v] = 1;
    end

    // R9 zero-seeded instance full cycle
    rst = 1; @(negedge clk); rst = 0; mz = '0; m = 4'b1000;
    for (int i = 0; i < N; i++) seen[i] = 0;
    for (int i = 0; i < N; i++) begin
      chk(!seen[stz], "R9", stz, -1);
      seen[stz] = 1;
      cyc(1);
    end
    chk(stz == 4'b0000, "R9", stz, 0);

    // R1 reset mid-run
    cyc(1); cyc(1);
    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    chk(st == 4'b1000, "R1", st, 8);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule